// File: doc/BRIEF.md
# Configuration Register Space with Memory Window Decode

This block is the configuration register file of one function on a 32-bit parallel-bus target. It also holds the address match logic that this configuration programs. The host reaches the block through a configuration port. An access counts only when this slot's own select line is high. The access names a dword index from 0 to 63, which covers a 256-byte space. Writes carry four active-low byte enables. Read data comes back one clock after the request.

The lower sixteen dwords form the fixed header. It holds the identity constants, a command word, one memory base register, and the interrupt routing byte. The upper forty-eight dwords are plain storage for driver software.

The host sizes the memory base register by writing all ones and reading the value back. It then writes the assigned base and sets the memory-enable command bit. From then on, the block raises a hit flag one clock after any memory-space address that falls inside the assigned window.

Top module: `cfg_space_bar`

## Requirements
- R1: After reset, reads return the following. Dword 0 is {DEVICE_ID, VENDOR_ID}, with the vendor in bits 15:0. Dword 2 is {CLASS_CODE, REVISION}, with the revision in bits 7:0. Dword 3 has HDR_TYPE in bits 23:16. Dword 15 has INT_PIN in bits 15:8. The command word, the base register, the interrupt line and every user dword read zero.
- R2: An access with cfg_sel low has no effect. A write is discarded, and a read produces no cfg_rvalid and leaves cfg_rdata at zero.
- R3: A selected read gives cfg_rvalid high for exactly the next clock, with the data. Whenever cfg_rvalid is low, cfg_rdata is zero.
- R4: Dwords 0, 2 and 3 are read-only, and writes to them leave their contents unchanged.
- R5: Header dwords 5 to 14 and the status half (bits 31:16) of dword 1 always read zero.
- R6: The base register at dword 4 has bits BAR_SIZE_LOG2-1:0 fixed at zero. Bit 0 = 0 marks memory space. With the default 4 KB window, writing FFFFFFFFh reads back FFFFF000h.
- R7: A write changes only the bytes whose enable is low. cfg_be_n[i] guards bits 8i+7:8i.
- R8: Dwords 16 to 63 (byte offsets 40h to FFh) are fully writable storage. They are little-endian: byte offset 4d+j sits in bits 8j+7:8j of dword d.
- R9: With memory enable set, mem_hit is high in the clock after a mem_req whose mem_addr bits 31:BAR_SIZE_LOG2 equal the programmed base. It is low after any other address, and low after any clock without mem_req.
- R10: While command bit 1 (memory enable) is clear, mem_hit stays low.
- R11: Dword 15 bits 7:0 hold a writable interrupt line, which the int_line output also shows. Bits 15:8 read the constant INT_PIN. Bits 31:16 read zero.
- R12: Only command bits 1 (memory enable) and 10 (interrupt disable) can be written. All other command bits read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sel | input | 1 | This slot's dedicated configuration select |
| cfg_req | input | 1 | Configuration access request |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_dw | input | 6 | Dword index in the 256-byte space |
| cfg_be_n | input | 4 | Active-low byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, zero when not valid |
| cfg_rvalid | output | 1 | Read data valid, one clock after the request |
| mem_req | input | 1 | Memory-space address phase present |
| mem_addr | input | 32 | Memory-space address |
| mem_hit | output | 1 | Address fell in the window (one clock later) |
| int_line | output | 8 | Programmed interrupt line value |

## Verification
The hardest state to reach from the ports is a window decode with a base that is only partly written. Software sizes the register, then rewrites some bytes under partial enables. The bench therefore probes the base register after an all-ones write, then overwrites a single byte lane. It reads the merged value back before it writes a full base. After that, the bench sweeps addresses across both edges of the window, first with memory enable clear and then with it set. The expected hit is computed as a range test on the address.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    localparam int CFG_DWORDS  = 64;
    localparam int HDR_DWORDS  = 16;
    localparam int USER_DWORDS = CFG_DWORDS - HDR_DWORDS;

    // Header dword indices that host software decodes
    localparam logic [5:0] DW_IDENT = 6'd0;
    localparam logic [5:0] DW_CMD   = 6'd1;
    localparam logic [5:0] DW_CLASS = 6'd2;
    localparam logic [5:0] DW_MISC  = 6'd3;
    localparam logic [5:0] DW_BASE  = 6'd4;
    localparam logic [5:0] DW_INTR  = 6'd15;

    // Writable command bits: memory enable (1), interrupt disable (10)
    localparam logic [15:0] CMD_WR_MASK = 16'h0402;
    localparam int          CMD_MEM_EN  = 1;

    typedef struct packed {
        logic        we;
        logic [5:0]  dw;
        logic [3:0]  be_n;
        logic [31:0] wdata;
    } cfg_op_t;

    // Merge new data into old under active-low byte enables
    function automatic logic [31:0] merge_bytes(input logic [31:0] old_v,
                                                input logic [31:0] new_v,
                                                input logic [3:0]  be_n);
        logic [31:0] r;
        r = old_v;
        for (int b = 0; b < 4; b++) begin
            if (!be_n[b]) r[8*b +: 8] = new_v[8*b +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/cfg_header.sv
module cfg_header
    import cfg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID     = 16'hC0DE,
    parameter logic [15:0] DEVICE_ID     = 16'h5A17,
    parameter logic [23:0] CLASS_CODE    = 24'h118000,
    parameter logic [7:0]  REVISION      = 8'h03,
    parameter logic [7:0]  HDR_TYPE      = 8'h00,
    parameter logic [7:0]  INT_PIN       = 8'h01,
    parameter int          BAR_SIZE_LOG2 = 12,
    localparam int         BASE_W        = 32 - BAR_SIZE_LOG2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  cfg_op_t           op,
    input  logic [5:0]        rd_dw,
    output logic [31:0]       rd_data,
    output logic              mem_en,
    output logic [BASE_W-1:0] bar_base,
    output logic [7:0]        int_line
);

    logic [15:0]       cmd_q;
    logic [BASE_W-1:0] bar_q;
    logic [7:0]        intl_q;

    logic [31:0] cmd_merged, bar_merged, intl_merged;

    always_comb begin
        cmd_merged  = merge_bytes({16'h0, cmd_q}, op.wdata, op.be_n);
        bar_merged  = merge_bytes({bar_q, {BAR_SIZE_LOG2{1'b0}}}, op.wdata, op.be_n);
        intl_merged = merge_bytes({24'h0, intl_q}, op.wdata, op.be_n);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            bar_q  <= '0;
            intl_q <= '0;
        end else if (wr_en) begin
            case (op.dw)
                DW_CMD:  cmd_q  <= cmd_merged[15:0] & CMD_WR_MASK;
                DW_BASE: bar_q  <= bar_merged[31:BAR_SIZE_LOG2];
                DW_INTR: intl_q <= intl_merged[7:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (rd_dw)
            DW_IDENT: rd_data = {DEVICE_ID, VENDOR_ID};
            DW_CMD:   rd_data = {16'h0, cmd_q};
            DW_CLASS: rd_data = {CLASS_CODE, REVISION};
            DW_MISC:  rd_data = {8'h00, HDR_TYPE, 16'h0000};
            DW_BASE:  rd_data = {bar_q, {BAR_SIZE_LOG2{1'b0}}};
            DW_INTR:  rd_data = {16'h0, INT_PIN, intl_q};
            default:  rd_data = '0;
        endcase
    end

    assign mem_en   = cmd_q[CMD_MEM_EN];
    assign bar_base = bar_q;
    assign int_line = intl_q;

endmodule

// File: rtl/cfg_user_store.sv
module cfg_user_store
    import cfg_pkg::*;
#(
    parameter int  NUM_DW = USER_DWORDS,
    localparam int IDX_W  = $clog2(NUM_DW)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [3:0]       be_n,
    input  logic [31:0]      wdata,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_data
);

    logic [31:0] store [NUM_DW];

    for (genvar g = 0; g < NUM_DW; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                store[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                store[g] <= merge_bytes(store[g], wdata, be_n);
            end
        end
    end

    always_comb begin
        if (int'(rd_idx) < NUM_DW) rd_data = store[rd_idx];
        else                       rd_data = '0;
    end

endmodule

// File: rtl/bar_match.sv
module bar_match #(
    parameter int BASE_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mem_en,
    input  logic [BASE_W-1:0] bar_base,
    input  logic              mem_req,
    input  logic [BASE_W-1:0] addr_hi,
    output logic              hit
);

    always_ff @(posedge clk) begin
        if (rst) hit <= 1'b0;
        else     hit <= mem_req && mem_en && (addr_hi == bar_base);
    end

endmodule

// File: rtl/cfg_space_bar.sv
module cfg_space_bar
    import cfg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID     = 16'hC0DE,
    parameter logic [15:0] DEVICE_ID     = 16'h5A17,
    parameter logic [23:0] CLASS_CODE    = 24'h118000,
    parameter logic [7:0]  REVISION      = 8'h03,
    parameter logic [7:0]  HDR_TYPE      = 8'h00,
    parameter logic [7:0]  INT_PIN       = 8'h01,
    parameter int          BAR_SIZE_LOG2 = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_sel,
    input  logic        cfg_req,
    input  logic        cfg_we,
    input  logic [5:0]  cfg_dw,
    input  logic [3:0]  cfg_be_n,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        cfg_rvalid,
    input  logic        mem_req,
    input  logic [31:0] mem_addr,
    output logic        mem_hit,
    output logic [7:0]  int_line
);

    localparam int BASE_W = 32 - BAR_SIZE_LOG2;
    localparam int UIDX_W = $clog2(USER_DWORDS);

    cfg_op_t           op;
    logic              accept, in_hdr, hdr_wr, usr_wr, rd_go;
    logic [31:0]       hdr_rd, usr_rd, rd_mux;
    logic [UIDX_W-1:0] usr_idx;
    logic              mem_en_w;
    logic [BASE_W-1:0] bar_base_w;
    logic              unused_low;

    assign op         = '{we: cfg_we, dw: cfg_dw, be_n: cfg_be_n, wdata: cfg_wdata};
    assign accept     = cfg_req && cfg_sel;
    assign in_hdr     = cfg_dw < 6'(HDR_DWORDS);
    assign hdr_wr     = accept && cfg_we && in_hdr;
    assign usr_wr     = accept && cfg_we && !in_hdr;
    assign rd_go      = accept && !cfg_we;
    assign usr_idx    = UIDX_W'(cfg_dw - 6'(HDR_DWORDS));
    assign unused_low = ^mem_addr[BAR_SIZE_LOG2-1:0];

    cfg_header #(
        .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .CLASS_CODE(CLASS_CODE),
        .REVISION(REVISION), .HDR_TYPE(HDR_TYPE), .INT_PIN(INT_PIN),
        .BAR_SIZE_LOG2(BAR_SIZE_LOG2)
    ) u_header (
        .clk(clk), .rst(rst), .wr_en(hdr_wr), .op(op), .rd_dw(cfg_dw),
        .rd_data(hdr_rd), .mem_en(mem_en_w), .bar_base(bar_base_w),
        .int_line(int_line)
    );

    cfg_user_store #(.NUM_DW(USER_DWORDS)) u_user (
        .clk(clk), .rst(rst), .wr_en(usr_wr), .wr_idx(usr_idx),
        .be_n(cfg_be_n), .wdata(cfg_wdata), .rd_idx(usr_idx), .rd_data(usr_rd)
    );

    bar_match #(.BASE_W(BASE_W)) u_match (
        .clk(clk), .rst(rst), .mem_en(mem_en_w), .bar_base(bar_base_w),
        .mem_req(mem_req), .addr_hi(mem_addr[31:BAR_SIZE_LOG2]), .hit(mem_hit)
    );

    assign rd_mux = in_hdr ? hdr_rd : usr_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_rvalid <= 1'b0;
            cfg_rdata  <= '0;
        end else begin
            cfg_rvalid <= rd_go;
            cfg_rdata  <= rd_go ? rd_mux : 32'h0;
        end
    end

endmodule

// File: rtl/cfg_space_chk.sv
module cfg_space_chk #(
    parameter logic [15:0] VENDOR_ID     = 16'hC0DE,
    parameter logic [15:0] DEVICE_ID     = 16'h5A17,
    parameter int          BAR_SIZE_LOG2 = 12
) (
    input logic        clk,
    input logic        rst,
    input logic        cfg_sel,
    input logic        cfg_req,
    input logic        cfg_we,
    input logic [5:0]  cfg_dw,
    input logic [31:0] cfg_rdata,
    input logic        cfg_rvalid,
    input logic        mem_req,
    input logic        mem_hit,
    input logic        mem_en
);

    // R2
    unselected_read_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_rvalid |-> $past(cfg_sel && cfg_req && !cfg_we));

    // R3
    idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_rvalid |-> (cfg_rdata == 32'h0));

    // R3
    rvalid_single_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_rvalid && !$past(cfg_req)) |-> 1'b0);

    // R4
    ident_constant_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_rvalid && $past(cfg_dw) == 6'd0) |-> (cfg_rdata == {DEVICE_ID, VENDOR_ID}));

    // R6
    base_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_rvalid && $past(cfg_dw) == 6'd4) |-> (cfg_rdata[BAR_SIZE_LOG2-1:0] == '0));

    // R9
    hit_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        mem_hit |-> $past(mem_req));

    // R10
    hit_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        mem_hit |-> $past(mem_en));

endmodule

bind cfg_space_bar cfg_space_chk #(
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .BAR_SIZE_LOG2(BAR_SIZE_LOG2)
) u_chk (
    .clk(clk), .rst(rst), .cfg_sel(cfg_sel), .cfg_req(cfg_req), .cfg_we(cfg_we),
    .cfg_dw(cfg_dw), .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
    .mem_req(mem_req), .mem_hit(mem_hit), .mem_en(mem_en_w)
);

// File: tb/test_cfg_space_bar.sv
module test_cfg_space_bar;

    localparam logic [15:0] VEN  = 16'hC0DE;
    localparam logic [15:0] DEV  = 16'h5A17;
    localparam logic [23:0] CLS  = 24'h118000;
    localparam logic [7:0]  REV  = 8'h03;
    localparam logic [7:0]  HTYP = 8'h00;
    localparam logic [7:0]  IPIN = 8'h01;
    localparam int          SL2  = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_sel = 1'b0, cfg_req = 1'b0, cfg_we = 1'b0;
    logic [5:0]  cfg_dw = '0;
    logic [3:0]  cfg_be_n = 4'hF;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cfg_rvalid;
    logic        mem_req = 1'b0;
    logic [31:0] mem_addr = '0;
    logic        mem_hit;
    logic [7:0]  int_line;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    logic [31:0] user_model [64];

    always #2 clk = ~clk;

    cfg_space_bar #(
        .VENDOR_ID(VEN), .DEVICE_ID(DEV), .CLASS_CODE(CLS), .REVISION(REV),
        .HDR_TYPE(HTYP), .INT_PIN(IPIN), .BAR_SIZE_LOG2(SL2)
    ) i_cfg_space_bar (
        .clk(clk), .rst(rst), .cfg_sel(cfg_sel), .cfg_req(cfg_req), .cfg_we(cfg_we),
        .cfg_dw(cfg_dw), .cfg_be_n(cfg_be_n), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_hit(mem_hit), .int_line(int_line)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic sel, input logic [5:0] dw,
                             input logic [3:0] be_n, input logic [31:0] d);
        @(negedge clk);
        cfg_sel = sel; cfg_req = 1'b1; cfg_we = 1'b1;
        cfg_dw = dw; cfg_be_n = be_n; cfg_wdata = d;
        @(negedge clk);
        cfg_req = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_be_n = 4'hF;
    endtask

    task automatic cfg_read(input logic sel, input logic [5:0] dw,
                            output logic [31:0] d, output logic v);
        @(negedge clk);
        cfg_sel = sel; cfg_req = 1'b1; cfg_we = 1'b0; cfg_dw = dw;
        @(negedge clk);
        d = cfg_rdata; v = cfg_rvalid;
        cfg_req = 1'b0; cfg_sel = 1'b0;
    endtask

    task automatic read_check(input string req, input logic [5:0] dw, input logic [31:0] exp);
        logic [31:0] d;
        logic v;
        cfg_read(1'b1, dw, d, v);
        check(req, {31'h0, v}, 32'h1);
        check(req, d, exp);
    endtask

    task automatic mem_probe(input string req, input logic req_on,
                             input logic [31:0] a, input logic exp);
        @(negedge clk);
        mem_req = req_on; mem_addr = a;
        @(negedge clk);
        check(req, {31'h0, mem_hit}, {31'h0, exp});
        mem_req = 1'b0;
    endtask

    function automatic logic [31:0] reset_val(input int dw);
        case (dw)
            0:       return {DEV, VEN};
            2:       return {CLS, REV};
            3:       return {8'h00, HTYP, 16'h0};
            15:      return {16'h0, IPIN, 8'h00};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                          input logic [3:0] be_n);
        logic [31:0] r;
        r = o;
        for (int b = 0; b < 4; b++) if (!be_n[b]) r[8*b +: 8] = n[8*b +: 8];
        return r;
    endfunction

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, base;
        logic v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 R5: reset state of the whole space, and idle outputs
        check("R1 rvalid idle", {31'h0, cfg_rvalid}, 32'h0);
        check("R1 hit idle", {31'h0, mem_hit}, 32'h0);
        check("R1 int_line", {24'h0, int_line}, 32'h0);
        for (int dw = 0; dw < 64; dw++) read_check("R1 R5 reset read", 6'(dw), reset_val(dw));

        // R3: data only for one clock, zero afterwards
        cfg_read(1'b1, 6'd0, d, v);
        @(negedge clk);
        check("R3 rvalid one clock", {31'h0, cfg_rvalid}, 32'h0);
        check("R3 rdata zero when idle", cfg_rdata, 32'h0);

        // R4: read-only identity words
        cfg_write(1'b1, 6'd0, 4'h0, 32'hFFFF_FFFF);
        cfg_write(1'b1, 6'd2, 4'h0, 32'h0000_0000);
        cfg_write(1'b1, 6'd3, 4'h0, 32'hFFFF_FFFF);
        read_check("R4 ident", 6'd0, reset_val(0));
        read_check("R4 class", 6'd2, reset_val(2));
        read_check("R4 misc", 6'd3, reset_val(3));

        // R5 R12: command writable mask, status zero
        cfg_write(1'b1, 6'd1, 4'h0, 32'hFFFF_FFFF);
        read_check("R12 R5 command mask", 6'd1, 32'h0000_0402);
        cfg_write(1'b1, 6'd1, 4'h0, 32'h0);
        for (int dw = 5; dw < 15; dw++) begin
            cfg_write(1'b1, 6'(dw), 4'h0, 32'hFFFF_FFFF);
            read_check("R5 unimplemented", 6'(dw), 32'h0);
        end

        // R6 R7: sizing probe then partial byte write
        cfg_write(1'b1, 6'd4, 4'h0, 32'hFFFF_FFFF);
        read_check("R6 size mask", 6'd4, 32'hFFFF_F000);
        cfg_write(1'b1, 6'd4, 4'b0111, 32'h1234_5678);
        read_check("R7 base byte3 only", 6'd4, 32'h12FF_F000);
        cfg_write(1'b1, 6'd4, 4'b1110, 32'h0000_00FF);
        read_check("R6 R7 low byte fixed", 6'd4, 32'h12FF_F000);
        base = 32'hA5A5_3000;
        cfg_write(1'b1, 6'd4, 4'h0, base);
        read_check("R6 base programmed", 6'd4, base);

        // R11: interrupt line
        cfg_write(1'b1, 6'd15, 4'h0, 32'hFFFF_FFFF);
        read_check("R11 intr word", 6'd15, {16'h0, IPIN, 8'hFF});
        check("R11 int_line port", {24'h0, int_line}, 32'hFF);
        cfg_write(1'b1, 6'd15, 4'b1110, 32'h0000_002B);
        read_check("R11 intr line", 6'd15, {16'h0, IPIN, 8'h2B});
        check("R11 int_line port", {24'h0, int_line}, 32'h2B);

        // R8 R7: user region full then partial writes, little-endian bytes
        for (int dw = 16; dw < 64; dw++) begin
            user_model[dw] = 32'h0302_0100 + 32'h0404_0404 * dw;
            cfg_write(1'b1, 6'(dw), 4'h0, user_model[dw]);
        end
        for (int dw = 16; dw < 64; dw++) begin
            logic [31:0] nv;
            nv = ~user_model[dw] ^ (32'h1111_1111 * dw);
            user_model[dw] = merge(user_model[dw], nv, 4'(dw));
            cfg_write(1'b1, 6'(dw), 4'(dw), nv);
        end
        for (int dw = 16; dw < 64; dw++) read_check("R8 R7 user store", 6'(dw), user_model[dw]);
        read_check("R8 byte offset 40h lane0", 6'd16,
                   merge(32'h0, 32'h4342_4140, 4'hF) | user_model[16]);

        // R2: unselected accesses
        cfg_write(1'b0, 6'd20, 4'h0, 32'hDEAD_BEEF);
        cfg_write(1'b0, 6'd15, 4'h0, 32'h0000_0077);
        cfg_read(1'b0, 6'd0, d, v);
        check("R2 no rvalid", {31'h0, v}, 32'h0);
        check("R2 rdata zero", d, 32'h0);
        read_check("R2 user unchanged", 6'd20, user_model[20]);
        check("R2 int_line unchanged", {24'h0, int_line}, 32'h2B);

        // R10: enable clear, no hits anywhere in window
        for (int k = 0; k < 8; k++) mem_probe("R10 disabled", 1'b1, base + 32'h200 * k, 1'b0);

        // R9: enable memory decoding, sweep across window edges
        cfg_write(1'b1, 6'd1, 4'h0, 32'h0000_0002);
        read_check("R12 mem enable", 6'd1, 32'h0000_0002);
        for (int k = 0; k < 24; k++) begin
            logic [31:0] a;
            a = base - 32'h2000 + 32'h0000_0333 * k;
            mem_probe("R9 sweep", 1'b1, a, (a >= base) && (a < base + 32'h1000));
        end
        mem_probe("R9 first byte", 1'b1, base, 1'b1);
        mem_probe("R9 last byte", 1'b1, base + 32'hFFF, 1'b1);
        mem_probe("R9 past end", 1'b1, base + 32'h1000, 1'b0);
        mem_probe("R9 before start", 1'b1, base - 32'h1, 1'b0);
        mem_probe("R9 no request", 1'b0, base, 1'b0);
        cfg_write(1'b1, 6'd1, 4'h0, 32'h0);
        mem_probe("R10 cleared again", 1'b1, base, 1'b0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule